// File: doc/BRIEF.md
# Hierarchical Interrupt Status Aggregator

This block holds a master summary register for several status sources: a bit-error-rate tester, an HDLC controller, a far-end alarm code detector, and a bank of second-order framers. The framers report loss-of-frame/AIS changes, remote-alarm changes and active loopback commands. Five summary bits latch when their source reports a qualifying event. The sixth bit follows a live level. A host-writable mask chooses which summary bits drive one active-high interrupt line.

The host reaches the block through an address, a read strobe, a write strobe and data buses. Reading the master register only observes it. Each latched bit is acknowledged when the host reads the status register of the matching subordinate. The block decodes such reads from the host address into single-cycle clear strobes. It returns zero data for those addresses, because the subordinate data is muxed elsewhere. Read data is registered and is valid in the cycle after the read strobe.

Each latched bit is held by its own two-state controller. The states are `ST_IDLE` (nothing pending) and `ST_PEND` (event pending). There are two transitions. CAPTURE goes from `ST_IDLE` to `ST_PEND` on a qualified event. ACK goes from `ST_PEND` to `ST_IDLE` on a clear strobe when no event arrives in the same cycle. Every other case holds the state.

Top module: `irq_status_hub`

## Requirements
- R1: A read at address 0 returns the master register one cycle later. The bit positions are: 2 tester change, 3 HDLC change, 4 far-end code, 5 framer LOF/AIS change, 6 framer remote-alarm change, 8 loopback active. All other bits read zero.
- R2: With `bert_ien`=1, any one of `bert_sync_chg`, `bert_bit_err`, `bert_bitcnt_ovf` or `bert_errcnt_ovf` sets bit 2.
- R3: When its enable input is 0, an event on the tester, HDLC, LOF/AIS or remote-alarm source leaves its bit unchanged.
- R4: A read at the matching subordinate address clears the bit. The addresses are 2 for the tester (bit 2), 3 for HDLC (bit 3), 4 for far-end (bit 4), 5 for LOF/AIS (bit 5) and 6 for remote-alarm (bit 6). A read at any other address leaves the bit set.
- R5: `feac_word_ok` sets bit 4 with no enable needed.
- R6: Bits 5 and 6 set when any one or more framers pulse their event lines.
- R7: Bit 8 is high exactly while any bit of `lb_active` is high. It never latches.
- R8: When an event and its clearing read occur in the same cycle, the bit stays set.
- R9: Reading address 0 changes no status bit.
- R10: The mask register is at address 1 and resets to zero. Only bits 2 to 6 and bit 8 are writable, so a write of 0xFFFF reads back as 0x017C.
- R11: `irq` is high exactly when some master bit is set and its mask bit is one.
- R12: A latched bit keeps its value in every cycle that has no event and no clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | ADDR_W | Host register address |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered host read data |
| bert_ien | input | 1 | Tester change enable |
| bert_sync_chg | input | 1 | Tester sync entered or left |
| bert_bit_err | input | 1 | Tester bit error seen |
| bert_bitcnt_ovf | input | 1 | Tester bit counter overflow |
| bert_errcnt_ovf | input | 1 | Tester error counter overflow |
| hdlc_ien | input | 1 | HDLC change enable |
| hdlc_chg | input | 1 | HDLC status change |
| feac_word_ok | input | 1 | New verified 16-bit far-end code word |
| lofais_ien | input | 1 | LOF/AIS change enable |
| lofais_chg | input | NUM_FRAMERS | Per-framer LOF/AIS change |
| rai_ien | input | 1 | Remote-alarm change enable |
| rai_chg | input | NUM_FRAMERS | Per-framer remote-alarm change |
| lb_active | input | NUM_FRAMERS | Per-framer loopback command active |
| irq | output | 1 | Masked interrupt, active high |

## Verification
The main check is a table of vectors. It pulses each tester event cause alone, so a missing term in the four-way OR shows up. It also pulses single framers and all framers together, which separates the cross-framer OR from a single-lane tap. Other vectors pair events with reads at the right address and at a wrong address, and one vector makes an event and its clearing read coincide. These show whether clearing is tied to the correct subordinate address and whether the event takes priority. Directed tests then use a partial mask, so that an interrupt from an unmasked bit can be told apart from any-bit behaviour. They also hold loopback high while the mask is zero after reset.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
    localparam int REG_W       = 16;
    localparam int NUM_LATCHED = 5;
    localparam int FIRST_BIT   = 2;
    localparam int LB_BIT      = 8;
    localparam logic [REG_W-1:0] VALID_MASK = 16'h017C;

    typedef enum logic {
        ST_IDLE,
        ST_PEND
    } latch_state_e;

    // latched sources sit at consecutive positions from FIRST_BIT
    function automatic int src_bit(input int idx);
        return FIRST_BIT + idx;
    endfunction
endpackage

// File: rtl/hub_decode.sv
module hub_decode #(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] A_MSR  = 0,
    parameter logic [ADDR_W-1:0] A_MASK = 1,
    parameter logic [ADDR_W-1:0] A_BERT = 2,
    parameter logic [ADDR_W-1:0] A_HDLC = 3,
    parameter logic [ADDR_W-1:0] A_FEAC = 4,
    parameter logic [ADDR_W-1:0] A_LOF  = 5,
    parameter logic [ADDR_W-1:0] A_RAI  = 6
) (
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    output logic              msr_rd,
    output logic              mask_rd,
    output logic              mask_wr,
    output logic [4:0]        clr_stb
);
    localparam logic [ADDR_W-1:0] CLR_ADDR [5] = '{A_BERT, A_HDLC, A_FEAC, A_LOF, A_RAI};

    assign msr_rd  = host_rd && (host_addr == A_MSR);
    assign mask_rd = host_rd && (host_addr == A_MASK);
    assign mask_wr = host_wr && (host_addr == A_MASK);

    for (genvar g = 0; g < 5; g++) begin : g_clr
        assign clr_stb[g] = host_rd && (host_addr == CLR_ADDR[g]);
    end
endmodule

// File: rtl/event_qualify.sv
module event_qualify #(
    parameter int N = 1
) (
    input  logic [N-1:0] evt,
    input  logic         ien,
    output logic         qual
);
    assign qual = ien && (|evt);
endmodule

// File: rtl/status_latch.sv
module status_latch
    import irq_hub_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic pend
);
    latch_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (evt)         st_d = ST_PEND;   // CAPTURE
            ST_PEND: if (clr && !evt) st_d = ST_IDLE;   // ACK
        endcase
    end

    always_comb pend = (st_q == ST_PEND);

    // R2
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> pend);
    // R8
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && clr && evt) |=> pend);
    // R4
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && clr && !evt) |=> !pend);
    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && !clr) |=> $stable(pend));
endmodule

// File: rtl/irq_status_hub.sv
module irq_status_hub
    import irq_hub_pkg::*;
#(
    parameter int NUM_FRAMERS = 7,
    parameter int ADDR_W      = 4,
    parameter logic [ADDR_W-1:0] ADDR_MSR  = 0,
    parameter logic [ADDR_W-1:0] ADDR_MASK = 1,
    parameter logic [ADDR_W-1:0] ADDR_BERT = 2,
    parameter logic [ADDR_W-1:0] ADDR_HDLC = 3,
    parameter logic [ADDR_W-1:0] ADDR_FEAC = 4,
    parameter logic [ADDR_W-1:0] ADDR_LOF  = 5,
    parameter logic [ADDR_W-1:0] ADDR_RAI  = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      host_addr,
    input  logic                   host_rd,
    input  logic                   host_wr,
    input  logic [15:0]            host_wdata,
    output logic [15:0]            host_rdata,
    input  logic                   bert_ien,
    input  logic                   bert_sync_chg,
    input  logic                   bert_bit_err,
    input  logic                   bert_bitcnt_ovf,
    input  logic                   bert_errcnt_ovf,
    input  logic                   hdlc_ien,
    input  logic                   hdlc_chg,
    input  logic                   feac_word_ok,
    input  logic                   lofais_ien,
    input  logic [NUM_FRAMERS-1:0] lofais_chg,
    input  logic                   rai_ien,
    input  logic [NUM_FRAMERS-1:0] rai_chg,
    input  logic [NUM_FRAMERS-1:0] lb_active,
    output logic                   irq
);
    logic                   msr_rd, mask_rd, mask_wr;
    logic [NUM_LATCHED-1:0] clr_stb;
    logic [NUM_LATCHED-1:0] qual;
    logic [NUM_LATCHED-1:0] pend;
    logic [REG_W-1:0]       mask_q;
    logic [REG_W-1:0]       msr_vec;
    logic                   lb_any;

    hub_decode #(
        .ADDR_W(ADDR_W), .A_MSR(ADDR_MSR), .A_MASK(ADDR_MASK),
        .A_BERT(ADDR_BERT), .A_HDLC(ADDR_HDLC), .A_FEAC(ADDR_FEAC),
        .A_LOF(ADDR_LOF), .A_RAI(ADDR_RAI)
    ) decode_i (
        .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
        .msr_rd(msr_rd), .mask_rd(mask_rd), .mask_wr(mask_wr),
        .clr_stb(clr_stb)
    );

    event_qualify #(.N(4)) q_bert_i (
        .evt({bert_sync_chg, bert_bit_err, bert_bitcnt_ovf, bert_errcnt_ovf}),
        .ien(bert_ien), .qual(qual[0]));
    event_qualify #(.N(1)) q_hdlc_i (.evt(hdlc_chg), .ien(hdlc_ien), .qual(qual[1]));
    event_qualify #(.N(1)) q_feac_i (.evt(feac_word_ok), .ien(1'b1), .qual(qual[2]));
    event_qualify #(.N(NUM_FRAMERS)) q_lof_i (.evt(lofais_chg), .ien(lofais_ien), .qual(qual[3]));
    event_qualify #(.N(NUM_FRAMERS)) q_rai_i (.evt(rai_chg), .ien(rai_ien), .qual(qual[4]));

    for (genvar g = 0; g < NUM_LATCHED; g++) begin : g_latch
        status_latch latch_i (
            .clk(clk), .rst_n(rst_n), .evt(qual[g]), .clr(clr_stb[g]), .pend(pend[g]));
    end

    assign lb_any = |lb_active;

    always_comb begin
        msr_vec = '0;
        for (int i = 0; i < NUM_LATCHED; i++) msr_vec[src_bit(i)] = pend[i];
        msr_vec[LB_BIT] = lb_any;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= host_wdata & VALID_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       host_rdata <= '0;
        else if (host_rd) host_rdata <= msr_rd ? msr_vec : (mask_rd ? mask_q : '0);
    end

    assign irq = |(msr_vec & mask_q);

    // R9
    msr_read_pure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == ADDR_MSR && qual == '0) |=> (pend == $past(pend)));
    // R1
    rdata_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && !host_wr) |=> (host_rdata[LB_BIT] == $past(lb_any)));
endmodule

// File: tb/irq_status_hub_tb_top.sv
`timescale 1ns/1ps
module irq_status_hub_tb_top;
    localparam int NF = 7;
    localparam int VW = 56;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [3:0] host_addr = '0;
    logic host_rd = 0, host_wr = 0;
    logic [15:0] host_wdata = '0, host_rdata;
    logic bert_ien = 0, bert_sync_chg = 0, bert_bit_err = 0, bert_bitcnt_ovf = 0, bert_errcnt_ovf = 0;
    logic hdlc_ien = 0, hdlc_chg = 0, feac_word_ok = 0, lofais_ien = 0, rai_ien = 0;
    logic [NF-1:0] lofais_chg = '0, rai_chg = '0, lb_active = '0;
    logic irq;
    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    irq_status_hub #(.NUM_FRAMERS(NF)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .bert_ien(bert_ien), .bert_sync_chg(bert_sync_chg), .bert_bit_err(bert_bit_err),
        .bert_bitcnt_ovf(bert_bitcnt_ovf), .bert_errcnt_ovf(bert_errcnt_ovf),
        .hdlc_ien(hdlc_ien), .hdlc_chg(hdlc_chg), .feac_word_ok(feac_word_ok),
        .lofais_ien(lofais_ien), .lofais_chg(lofais_chg), .rai_ien(rai_ien),
        .rai_chg(rai_chg), .lb_active(lb_active), .irq(irq));

    // fields: req, ien{bert,hdlc,lof,rai}, bert{sync,err,bitovf,errovf}, hdlc, feac, lof, rai, lb, rd, raddr, exp
    function automatic logic [VW-1:0] mkv(input logic [3:0] req, input logic [3:0] ien,
        input logic [3:0] bert, input logic hd, input logic fe, input logic [6:0] lof,
        input logic [6:0] rai, input logic [6:0] lb, input logic rd, input logic [3:0] ra,
        input logic [15:0] exp);
        return {req, ien, bert, hd, fe, lof, rai, lb, rd, ra, exp};
    endfunction

    localparam int NV = 32;
    localparam logic [VW-1:0] VEC [NV] = '{
        mkv(1,  4'hF, 4'h0, 0, 0, 7'h00, 7'h00, 7'h00, 0, 0, 16'h0000), // R1 idle
        mkv(2,  4'hF, 4'h8, 0, 0, 7'h00, 7'h00, 7'h00, 0, 0, 16'h0004), // R2 sync change
        mkv(4,  4'hF, 4'h0, 0, 0, 7'h00, 7'h00, 7'h00, 1, 2, 16'h0000), // R4
        mkv(2,  4'hF, 4'h4, 0, 0, 7'h00, 7'h00, 7'h00, 0, 0, 16'h0004), // R2 bit error
        mkv(4,  4'hF, 4'h0, 0, 0, 7'h00, 7'h00, 7'h00, 1, 2, 16'h0000),
        mkv(2,  4'hF, 4'h2, 0, 0, 7'h00, 7'h00, 7'h00, 0, 0, 16'h0004), // R2 bit counter ovf
        mkv(4,  4'hF, 4'h0, 0, 0, 7'h00, 7'h00, 7'h00, 1, 2, 16'h0000),
        mkv(2,  4'hF, 4'h1, 0, 0, 7'h00, 7'h00, 7'h00, 0, 0, 16'h0004), // R2 error counter ovf
        mkv(4,  4'hF, 4'h0, 0, 0, 7'h00, 7'h00, 7'h00, 1, 2, 16'h0000),
        mkv(12, 4'hF, 4'h0, 1, 0, 7'h00, 7'h00, 7'h00, 0, 0, 16'h0008), // R12 hdlc
        mkv(5,  4'hF, 4'h0, 0, 1, 7'h00, 7'h00, 7'h00, 0, 0, 16'h0018), // R5 far-end
        mkv(4,  4'hF, 4'h0, 0, 0, 7'h00, 7'h00, 7'h00, 1, 3, 16'h0010),
        mkv(4,  4'hF, 4'h0, 0, 0, 7'h00, 7'h00, 7'h00, 1, 4, 16'h0000),
        mkv(6,  4'hF, 4'h0, 0, 0, 7'h01, 7'h00, 7'h00, 0, 0, 16'h0020), // R6 one framer
        mkv(6,  4'hF, 4'h0, 0, 0, 7'h00, 7'h40, 7'h00, 0, 0, 16'h0060),
        mkv(4,  4'hF, 4'h0, 0, 0, 7'h00, 7'h00, 7'h00, 1, 5, 16'h0040),
        mkv(4,  4'hF, 4'h0, 0, 0, 7'h00, 7'h00, 7'h00, 1, 6, 16'h0000),
        mkv(7,  4'hF, 4'h0, 0, 0, 7'h00, 7'h00, 7'h08, 0, 0, 16'h0100), // R7 level
        mkv(7,  4'hF, 4'h0, 0, 0, 7'h00, 7'h00, 7'h0C, 0, 0, 16'h0100),
        mkv(7,  4'hF, 4'h0, 0, 0, 7'h00, 7'h00, 7'h00, 0, 0, 16'h0000),
        mkv(3,  4'h0, 4'hF, 1, 1, 7'h7F, 7'h7F, 7'h00, 0, 0, 16'h0010), // R3 enables off
        mkv(4,  4'hF, 4'h0, 0, 0, 7'h00, 7'h00, 7'h00, 1, 4, 16'h0000),
        mkv(2,  4'hF, 4'h8, 0, 0, 7'h00, 7'h00, 7'h00, 0, 0, 16'h0004),
        mkv(8,  4'hF, 4'h8, 0, 0, 7'h00, 7'h00, 7'h00, 1, 2, 16'h0004), // R8 event wins
        mkv(4,  4'hF, 4'h0, 0, 0, 7'h00, 7'h00, 7'h00, 1, 2, 16'h0000),
        mkv(4,  4'hF, 4'h8, 0, 0, 7'h00, 7'h00, 7'h00, 1, 3, 16'h0004), // R4 wrong address
        mkv(9,  4'hF, 4'h0, 0, 0, 7'h00, 7'h00, 7'h00, 1, 0, 16'h0004), // R9 master read
        mkv(4,  4'hF, 4'h0, 0, 0, 7'h00, 7'h00, 7'h00, 1, 2, 16'h0000),
        mkv(6,  4'hF, 4'h0, 0, 0, 7'h7F, 7'h22, 7'h00, 0, 0, 16'h0060), // R6 many framers
        mkv(12, 4'hF, 4'h0, 0, 0, 7'h00, 7'h00, 7'h00, 0, 0, 16'h0060), // R12 hold
        mkv(4,  4'hF, 4'h0, 0, 0, 7'h00, 7'h00, 7'h00, 1, 5, 16'h0040),
        mkv(4,  4'hF, 4'h0, 0, 0, 7'h00, 7'h00, 7'h00, 1, 6, 16'h0000)
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic clear_events();
        bert_sync_chg = 0; bert_bit_err = 0; bert_bitcnt_ovf = 0; bert_errcnt_ovf = 0;
        hdlc_chg = 0; feac_word_ok = 0; lofais_chg = '0; rai_chg = '0;
    endtask

    task automatic host_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
        @(posedge clk); @(negedge clk); host_wr = 0;
    endtask

    task automatic host_read(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk); host_rd = 1; host_addr = a;
        @(posedge clk); @(negedge clk); host_rd = 0; d = host_rdata;
    endtask

    task automatic pulse_bert();
        @(negedge clk); bert_sync_chg = 1; @(posedge clk); @(negedge clk); bert_sync_chg = 0;
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset rdata", host_rdata, 16'h0000);
        check("R11 reset irq", {15'd0, irq}, 16'h0000);
        rst_n = 1;
        // R10 mask resets to zero: loopback visible but no interrupt
        lb_active = 7'h10;
        host_read(0, rd);
        check("R7 loopback after reset", rd, 16'h0100);
        check("R10 zero mask gives no irq", {15'd0, irq}, 16'h0000);
        host_read(1, rd);
        check("R10 mask reset value", rd, 16'h0000);
        lb_active = '0;
        host_write(1, 16'hFFFF);
        host_read(1, rd);
        check("R10 mask writable bits", rd, 16'h017C);

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            @(negedge clk);
            {bert_ien, hdlc_ien, lofais_ien, rai_ien} = v[51:48];
            {bert_sync_chg, bert_bit_err, bert_bitcnt_ovf, bert_errcnt_ovf} = v[47:44];
            hdlc_chg = v[43]; feac_word_ok = v[42];
            lofais_chg = v[41:35]; rai_chg = v[34:28]; lb_active = v[27:21];
            host_rd = v[20]; host_addr = v[19:16];
            @(posedge clk); @(negedge clk);
            clear_events();
            host_rd = 1; host_addr = 0;
            @(posedge clk); @(negedge clk);
            host_rd = 0;
            check($sformatf("R%0d vector %0d status", v[55:52], i), host_rdata, v[15:0]);
            check($sformatf("R11 vector %0d irq", i), {15'd0, irq}, {15'd0, (v[15:0] != 0)});
        end
        lb_active = '0;
        {bert_ien, hdlc_ien, lofais_ien, rai_ien} = 4'hF;

        // R11 partial mask: only bit 2 enabled
        host_write(1, 16'h0004);
        @(negedge clk); hdlc_chg = 1; @(posedge clk); @(negedge clk); hdlc_chg = 0;
        check("R11 masked hdlc no irq", {15'd0, irq}, 16'h0000);
        pulse_bert();
        check("R11 unmasked tester irq", {15'd0, irq}, 16'h0001);
        host_read(2, rd);
        check("R11 irq drops after ack", {15'd0, irq}, 16'h0000);
        host_read(0, rd);
        check("R12 hdlc still pending", rd, 16'h0008);
        host_read(3, rd);
        host_read(0, rd);
        check("R4 hdlc acknowledged", rd, 16'h0000);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule